// File: doc/BRIEF.md
# Packed byte dot-product accumulator

This block is a SIMD integer datapath for a 256-bit operand that is split into eight 32-bit lanes. Each lane takes four byte pairs from sources A and B, multiplies each pair, and adds the four products to the matching 32-bit accumulator word from W. The result either wraps or saturates. A three-bit mode input sets the signedness of each source and turns saturation on or off. A width flag limits the operation to the low 128 bits, which leaves four lanes active.

The caller presents W, A, B, the mode and the width flag together with `in_valid`. The block registers them on that clock edge, and the packed result with `out_valid` appears one clock later. While `in_valid` is low the block holds its last result.

Top module: `bdot_acc`

## Requirements
- R1: Lane j (result bits 32j+31:32j) adds the products of A byte 4j+k and B byte 4j+k, for k = 0..3, to W bits 32j+31:32j. Byte n occupies bits 8n+7:8n of each source.
- R2: When mode bits 1:0 are 00, both A and B bytes are sign-extended before they are multiplied.
- R3: When mode bits 1:0 are 01, A bytes are sign-extended and B bytes are zero-extended.
- R4: When mode bits 1:0 are 10, both A and B bytes are zero-extended.
- R5: When mode bit 2 is 0, each lane result is the low 32 bits of the exact sum, so it wraps on overflow.
- R6: When mode bit 2 is 1 and bits 1:0 are 00 or 01, W is signed and each lane result is clamped to the range -2^31 to 2^31-1.
- R7: When mode bit 2 is 1 and bits 1:0 are 10, W is unsigned and each lane result is clamped to the range 0 to 2^32-1.
- R8: When `in_wide` is 0, only lanes 0..3 are computed and result bits 255:128 are zero. When `in_wide` is 1, all eight lanes are computed.
- R9: Mode bits 1:0 = 11 is reserved and gives an all-zero result.
- R10: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and the result of that operation is on `out_res` at the same time. A synchronous reset clears `out_valid`.
- R11: Inputs presented while `in_valid` is low are ignored, and `out_res` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request; the operands are captured on this edge |
| in_wide | input | 1 | 1 = eight lanes (256 bits), 0 = four lanes (128 bits) |
| in_mode | input | 3 | Bits 1:0 signedness (00 ss, 01 su, 10 uu, 11 reserved); bit 2 saturate |
| in_w | input | 256 | Accumulator words |
| in_a | input | 256 | Byte source A |
| in_b | input | 256 | Byte source B |
| out_valid | output | 1 | Result valid |
| out_res | output | 256 | Packed lane results |

## Verification
The operands and mode are held in one register stage, and the result is computed from those registers. A corrupted captured operand or mode bit therefore appears on `out_res` in the same cycle as `out_valid`, one clock after the request. The error stays visible until the next accepted request, because the registers are loaded only on `in_valid`. A wrong extension or clamp decision shows up only in the lanes whose bytes or sums reach that corner. For this reason the directed cases put -128 and 255 in all four byte positions and set W to both the signed and the unsigned extremes. The reserved code and the narrow width are checked across the whole 256-bit result.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int BYTE_W  = 8;
    localparam int LANE_W  = 32;
    localparam int LANE_B  = LANE_W / BYTE_W;
    localparam int PROD_W  = 2 * (BYTE_W + 1);
    localparam int SUM_W   = LANE_W + 4;

    typedef enum logic [1:0] {
        SGN_SGN = 2'b00,
        SGN_UNS = 2'b01,
        UNS_UNS = 2'b10,
        KIND_RSVD = 2'b11
    } sign_kind_e;

    typedef struct packed {
        logic       sat;
        sign_kind_e kind;
    } op_mode_t;

    function automatic logic signed [BYTE_W:0] widen_byte(
        input logic [BYTE_W-1:0] v,
        input logic              as_signed
    );
        return as_signed ? {v[BYTE_W-1], v} : {1'b0, v};
    endfunction

    function automatic logic a_is_signed(input sign_kind_e k);
        return (k != UNS_UNS);
    endfunction

    function automatic logic b_is_signed(input sign_kind_e k);
        return (k == SGN_SGN);
    endfunction

    function automatic logic w_is_unsigned(input op_mode_t m);
        return m.sat && (m.kind == UNS_UNS);
    endfunction

endpackage

// File: rtl/dp_lane.sv
module dp_lane
    import dp_pkg::*;
(
    input  op_mode_t                  mode,
    input  logic [LANE_W-1:0]         w,
    input  logic [LANE_W-1:0]         a,
    input  logic [LANE_W-1:0]         b,
    output logic signed [SUM_W-1:0]   sum
);

    logic signed [PROD_W-1:0] prod   [LANE_B];
    logic signed [SUM_W-1:0]  prod_x [LANE_B];
    logic signed [SUM_W-1:0]  w_ext;

    genvar k;
    generate
        for (k = 0; k < LANE_B; k++) begin : g_mul
            logic signed [BYTE_W:0] ea;
            logic signed [BYTE_W:0] eb;
            assign ea        = widen_byte(a[k*BYTE_W +: BYTE_W], a_is_signed(mode.kind));
            assign eb        = widen_byte(b[k*BYTE_W +: BYTE_W], b_is_signed(mode.kind));
            assign prod[k]   = ea * eb;
            assign prod_x[k] = prod[k];
        end
    endgenerate

    assign w_ext = w_is_unsigned(mode)
                 ? {{(SUM_W-LANE_W){1'b0}}, w}
                 : {{(SUM_W-LANE_W){w[LANE_W-1]}}, w};

    always_comb begin
        sum = w_ext;
        for (int i = 0; i < LANE_B; i++) begin
            sum = sum + prod_x[i];
        end
    end

endmodule

// File: rtl/dp_clamp.sv
module dp_clamp
    import dp_pkg::*;
(
    input  op_mode_t                  mode,
    input  logic signed [SUM_W-1:0]   sum,
    output logic [LANE_W-1:0]         res
);

    localparam logic signed [SUM_W-1:0] S_MAX =
        {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] S_MIN =
        {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] U_MAX =
        {{(SUM_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
    localparam logic signed [SUM_W-1:0] ZERO = '0;

    always_comb begin
        res = sum[LANE_W-1:0];
        if (mode.sat) begin
            if (mode.kind == UNS_UNS) begin
                if (sum < ZERO)       res = '0;
                else if (sum > U_MAX) res = '1;
            end else begin
                if (sum > S_MAX)      res = {1'b0, {(LANE_W-1){1'b1}}};
                else if (sum < S_MIN) res = {1'b1, {(LANE_W-1){1'b0}}};
            end
        end
    end

    // R7
    always_comb begin
        if (mode.sat && mode.kind == UNS_UNS && sum > U_MAX) begin
            uns_clamp_chk: assert (res == {LANE_W{1'b1}});
        end
    end

endmodule

// File: rtl/bdot_acc.sv
module bdot_acc
    import dp_pkg::*;
#(
    parameter int OPND_W   = 256,
    parameter int NARROW_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_wide,
    input  logic [2:0]        in_mode,
    input  logic [OPND_W-1:0] in_w,
    input  logic [OPND_W-1:0] in_a,
    input  logic [OPND_W-1:0] in_b,
    output logic              out_valid,
    output logic [OPND_W-1:0] out_res
);

    localparam int NUM_LANES    = OPND_W / LANE_W;
    localparam int NARROW_LANES = NARROW_W / LANE_W;

    logic              valid_q;
    logic              wide_q;
    op_mode_t          mode_q;
    logic [OPND_W-1:0] w_q;
    logic [OPND_W-1:0] a_q;
    logic [OPND_W-1:0] b_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            wide_q  <= 1'b0;
            mode_q  <= '0;
            w_q     <= '0;
            a_q     <= '0;
            b_q     <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                wide_q <= in_wide;
                mode_q <= op_mode_t'(in_mode);
                w_q    <= in_w;
                a_q    <= in_a;
                b_q    <= in_b;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            logic signed [SUM_W-1:0] lsum;
            logic [LANE_W-1:0]       lres;
            logic                    active;

            dp_lane u_lane (
                .mode (mode_q),
                .w    (w_q[g*LANE_W +: LANE_W]),
                .a    (a_q[g*LANE_W +: LANE_W]),
                .b    (b_q[g*LANE_W +: LANE_W]),
                .sum  (lsum)
            );

            dp_clamp u_clamp (
                .mode (mode_q),
                .sum  (lsum),
                .res  (lres)
            );

            if (g < NARROW_LANES) begin : g_low
                assign active = (mode_q.kind != KIND_RSVD);
            end else begin : g_high
                assign active = (mode_q.kind != KIND_RSVD) && wide_q;
            end

            assign out_res[g*LANE_W +: LANE_W] = active ? lres : '0;
        end
    endgenerate

    assign out_valid = valid_q;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !wide_q) |-> (out_res[OPND_W-1:NARROW_W] == '0));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mode_q.kind == KIND_RSVD) |-> (out_res == '0));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_res));

endmodule

// File: tb/bdot_acc_tb.sv
module bdot_acc_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_wide;
    logic [2:0]   in_mode;
    logic [255:0] in_w, in_a, in_b;
    logic         out_valid;
    logic [255:0] out_res;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bdot_acc u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
        .in_mode(in_mode), .in_w(in_w), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_res(out_res)
    );

    function automatic logic [31:0] ref_lane(input logic [2:0] m, input logic [31:0] w,
                                             input logic [31:0] a, input logic [31:0] b);
        longint s, pa, pb;
        if (m[1:0] == 2'b11) return 32'h0;
        if (m[2] && m[1:0] == 2'b10) s = longint'({32'h0, w});
        else                         s = longint'($signed(w));
        for (int i = 0; i < 4; i++) begin
            pa = (m[1:0] == 2'b10) ? longint'({56'h0, a[8*i +: 8]}) : longint'($signed(a[8*i +: 8]));
            pb = (m[1:0] == 2'b00) ? longint'($signed(b[8*i +: 8])) : longint'({56'h0, b[8*i +: 8]});
            s = s + pa * pb;
        end
        if (m[2]) begin
            if (m[1:0] == 2'b10) begin
                if (s < 0) s = 0;
                if (s > 64'sd4294967295) s = 64'sd4294967295;
            end else begin
                if (s > 64'sd2147483647) s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end
        end
        return s[31:0];
    endfunction

    task automatic check1(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [2:0] m, input logic wide,
                          input logic [255:0] w, input logic [255:0] a, input logic [255:0] b);
        logic [255:0] exp;
        in_valid = 1'b1; in_mode = m; in_wide = wide; in_w = w; in_a = a; in_b = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        exp = '0;
        for (int j = 0; j < 8; j++) begin
            if (wide || j < 4)
                exp[32*j +: 32] = ref_lane(m, w[32*j +: 32], a[32*j +: 32], b[32*j +: 32]);
        end
        check1({req, " R10 valid"}, {255'h0, out_valid}, 256'h1);
        check1(req, out_res, exp);
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom();
        return v;
    endfunction

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_wide = 1'b0; in_mode = 3'b0;
        in_w = '0; in_a = '0; in_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check1("R10 reset out_valid", {255'h0, out_valid}, 256'h0);
    endtask

    task automatic t_mapping();
        logic [255:0] a, b, w;
        // R1: distinct bytes per position expose a wrong byte or lane mapping
        for (int i = 0; i < 32; i++) begin
            a[8*i +: 8] = 8'(i + 1);
            b[8*i +: 8] = 8'(3 * i + 2);
        end
        for (int j = 0; j < 8; j++) w[32*j +: 32] = 32'(j * 1000);
        run_op("R1 mapping", 3'b000, 1'b1, w, a, b);
        run_op("R1 mapping uu", 3'b010, 1'b1, w, a, b);
    endtask

    task automatic t_modes();
        // R2 R3 R4 R5 R6 R7: every mode, wrapping and saturating, random data
        for (int r = 0; r < 6; r++) begin
            run_op("R2 ss wrap", 3'b000, 1'b1, rnd256(), rnd256(), rnd256());
            run_op("R3 su wrap", 3'b001, 1'b1, rnd256(), rnd256(), rnd256());
            run_op("R4 uu wrap", 3'b010, 1'b1, rnd256(), rnd256(), rnd256());
            run_op("R6 ss sat", 3'b100, 1'b1, rnd256(), rnd256(), rnd256());
            run_op("R6 su sat", 3'b101, 1'b1, rnd256(), rnd256(), rnd256());
            run_op("R7 uu sat", 3'b110, 1'b1, rnd256(), rnd256(), rnd256());
        end
    endtask

    task automatic t_corners();
        logic [255:0] neg, ff, smax, smin, umax, zero;
        neg = {32{8'h80}}; ff = {32{8'hFF}};
        smax = {8{32'h7FFFFFFF}}; smin = {8{32'h80000000}};
        umax = {8{32'hFFFFFFFF}}; zero = '0;
        // R5: -128*-128 four times on top of the signed maximum wraps
        run_op("R5 ss wrap max", 3'b000, 1'b1, smax, neg, neg);
        check1("R5 ss wrap value", {224'h0, out_res[31:0]}, 256'h8000FFFF);
        // R6: the same sum clamps at the signed maximum
        run_op("R6 ss sat max", 3'b100, 1'b1, smax, neg, neg);
        check1("R6 ss sat value", {224'h0, out_res[31:0]}, 256'h7FFFFFFF);
        // R3 R6: -128*255 four times on top of the signed minimum clamps at the minimum
        run_op("R6 su sat min", 3'b101, 1'b1, smin, neg, ff);
        check1("R6 su sat value", {224'h0, out_res[31:0]}, 256'h80000000);
        run_op("R3 su wrap min", 3'b001, 1'b1, smin, neg, ff);
        // R7: 255*255 four times on top of the unsigned maximum clamps at all ones
        run_op("R7 uu sat umax", 3'b110, 1'b1, umax, ff, ff);
        check1("R7 uu sat value", {224'h0, out_res[31:0]}, 256'hFFFFFFFF);
        // R5 R4: wrapping uu form gives 260100 - 1
        run_op("R5 uu wrap umax", 3'b010, 1'b1, umax, ff, ff);
        check1("R5 uu wrap value", {224'h0, out_res[31:0]}, 256'd260099);
        // R7: W = 0x80000000 is a large positive value in saturating uu
        run_op("R7 uu sat w high", 3'b110, 1'b1, smin, ff, ff);
        run_op("R2 ss neg zero w", 3'b000, 1'b1, zero, neg, ff);
        run_op("R6 ss sat smin", 3'b100, 1'b1, smin, neg, {32{8'h7F}});
    endtask

    task automatic t_narrow();
        // R8
        run_op("R8 narrow ss", 3'b000, 1'b0, rnd256(), rnd256(), rnd256());
        check1("R8 upper zero", {128'h0, out_res[255:128]}, 256'h0);
        run_op("R8 narrow uu sat", 3'b110, 1'b0, {8{32'hFFFFFFFF}}, {32{8'hFF}}, {32{8'hFF}});
        run_op("R8 wide again", 3'b001, 1'b1, rnd256(), rnd256(), rnd256());
    endtask

    task automatic t_reserved();
        // R9
        run_op("R9 reserved", 3'b011, 1'b1, rnd256(), rnd256(), rnd256());
        run_op("R9 reserved sat", 3'b111, 1'b1, {8{32'h12345678}}, rnd256(), rnd256());
    endtask

    task automatic t_hold();
        logic [255:0] keep;
        // R11: requests with in_valid low must not disturb the held result
        run_op("R11 setup", 3'b000, 1'b1, rnd256(), rnd256(), rnd256());
        keep = out_res;
        in_valid = 1'b0; in_mode = 3'b010; in_wide = 1'b0;
        in_w = rnd256(); in_a = rnd256(); in_b = rnd256();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check1("R11 held result", out_res, keep);
        check1("R11 R10 no valid", {255'h0, out_valid}, 256'h0);
    endtask

    initial begin
        t_reset();
        t_mapping();
        t_modes();
        t_corners();
        t_narrow();
        t_reserved();
        t_hold();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule